// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Controller

This block sequences the two gate enables of a synchronous half-bridge from a single PWM command. While the block is enabled, the high-side enable tracks the PWM level and the low-side enable tracks its inverse. A handoff gap is inserted at every transition so that the two enables are never on in the same cycle. The block also takes two digitized comparator flags on the switch node: "node high" and "node below 1 V". The PWM input, the two flags and the enable are sampled on the block clock.

When the high side is switched off, the low side waits until the switch node has been seen high and has then dropped below the threshold flag. If the node was never seen high, the low side comes on after a fixed fallback delay instead. If the node was seen high but never drops, a timeout turns the low side on anyway, which covers negative inductor current. When the low side is switched off, a fixed dead time is counted before the high side turns on. Every delay is a whole number of clock cycles set by a parameter. The PWM input and both flags pass through a two-flop synchronizer. An input edge therefore reaches the gate outputs on the third rising clock edge after it.

Top module: `gate_deadtime_ctrl`

## Requirements
- R1: While enabled, an edge of the PWM input that needs no dead time (high-side turn-off) changes the gate outputs on the third rising clock edge after it. In steady state the high-side output equals PWM and the low-side output equals its inverse.
- R2: Whenever enable is sampled low on a rising edge, both outputs are low from that edge on. Both stay low, whatever PWM and the node flags do, until enable is sampled high again.
- R3: The high-side and low-side outputs are never high in the same cycle.
- R4: After the high side turns off, if node-high has been seen and node-below-threshold then asserts, the low side turns on at the third rising edge after the flag asserts. This applies when that edge comes before the fixed delay (R5) and the timeout (R6) would act.
- R5: If node-high was not seen after the high-side turn-off, the low side turns on FIXED_DLY (default 15) cycles after the high side turned off.
- R6: If node-high was seen but node-below-threshold never asserts, the low side turns on TIMEOUT_DLY (default 19) cycles after the high side turned off.
- R7: From low-side turn-off to high-side turn-on, both outputs stay low for exactly DEAD_LH (default 3) cycles.
- R8: If PWM rises again while a low-side turn-on is pending, the low side never asserts. The high side turns on after the DEAD_LH dead time, six rising edges after the PWM edge with defaults.
- R9: On enable with PWM already high, the first high-side turn-on observes the dead time: it happens DEAD_LH+1 edges after the enable edge. On enable with PWM low, the low side comes on through the fixed-delay path, FIXED_DLY+1 edges after the enable edge.
- R10: During reset both outputs are low, and every counter and the state are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enIn | input | 1 | Drive enable, sampled on clk |
| pwmIn | input | 1 | PWM command, asynchronous |
| nodeHighIn | input | 1 | Switch node high flag, asynchronous |
| nodeLowIn | input | 1 | Switch node below 1 V flag, asynchronous |
| hsGateOut | output | 1 | High-side gate enable |
| lsGateOut | output | 1 | Low-side gate enable |

## Verification
The checks embedded in the design assume that the two node flags are never asserted together, because the node cannot be both high and below 1 V. They also assume that enable is a synchronous signal, and that a node flag held across the high-side turn-off edge is a legitimate observation. The stimulus only changes inputs between clock edges. Whenever it raises node-below-threshold, it clears node-high first. It draws PWM widths, node behaviours (none, rise then fall, rise only, fall only) and short low phases that force cancellation from a fixed-seed random stream. These random cases are mixed with directed cases for each delay path.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_HS   = 3'd1,
    ST_WAIT = 3'd2,
    ST_LS   = 3'd3,
    ST_DEAD = 3'd4
  } dtcState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic seenClr;
  } dtcStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic fixedHit;
    logic toutHit;
    logic deadHit;
    logic seen;
  } dtcStatus_t;

endpackage

// File: rtl/dtc_sync.sv
module dtc_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[g] <= '0;
          else       stageQ[g] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[g] <= '0;
          else       stageQ[g] <= stageQ[g-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/dtc_datapath.sv
module dtc_datapath
  import dtc_pkg::*;
#(
  parameter int CNT_W       = 5,
  parameter int FIXED_DLY   = 15,
  parameter int TIMEOUT_DLY = 19,
  parameter int DEAD_LH     = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       highS,
  input  dtcStrobe_t strobe,
  output dtcStatus_t status
);

  localparam logic [CNT_W-1:0] FIX_LAST  = CNT_W'(FIXED_DLY - 1);
  localparam logic [CNT_W-1:0] TOUT_LAST = CNT_W'(TIMEOUT_DLY - 1);
  localparam logic [CNT_W-1:0] DEAD_LAST = CNT_W'(DEAD_LH - 1);

  logic [CNT_W-1:0] cntQ;
  logic             seenQ;

  // shared delay counter for fallback, timeout and dead time
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cntQ <= '0;
    else if (strobe.cntClr) cntQ <= '0;
    else if (strobe.cntInc) cntQ <= cntQ + 1'b1;
  end

  // node-high observed since the last high-side turn-off
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               seenQ <= 1'b0;
    else if (strobe.seenClr) seenQ <= 1'b0;
    else if (highS)          seenQ <= 1'b1;
  end

  always_comb begin
    status.fixedHit = (cntQ == FIX_LAST);
    status.toutHit  = (cntQ == TOUT_LAST);
    status.deadHit  = (cntQ == DEAD_LAST);
    status.seen     = seenQ;
  end

  // R6: the counter never wraps while counting a window
  p_cnt_no_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cntInc && !strobe.cntClr) |-> (cntQ != {CNT_W{1'b1}}));

  // R10: a cleared counter reads zero on the next cycle
  p_cnt_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntClr |=> (cntQ == '0));

endmodule

// File: rtl/dtc_ctrl.sv
module dtc_ctrl
  import dtc_pkg::*;
#(
  parameter int CNT_W       = 5,
  parameter int FIXED_DLY   = 15,
  parameter int TIMEOUT_DLY = 19,
  parameter int DEAD_LH     = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enIn,
  input  logic       pwmS,
  input  logic       lowS,
  input  dtcStatus_t status,
  output dtcStrobe_t strobe,
  output logic       hsGate,
  output logic       lsGate
);

  dtcState_e stateQ, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_OFF;
    else       stateQ <= stateNext;
  end

  always_comb begin
    stateNext = stateQ;
    strobe    = '0;
    if (!enIn) begin
      stateNext = ST_OFF;
    end else begin
      case (stateQ)
        ST_OFF: begin
          strobe.cntClr = 1'b1;
          if (pwmS) begin
            stateNext = ST_DEAD;
          end else begin
            stateNext      = ST_WAIT;
            strobe.seenClr = 1'b1;
          end
        end
        ST_HS: begin
          if (!pwmS) begin
            stateNext      = ST_WAIT;
            strobe.cntClr  = 1'b1;
            strobe.seenClr = 1'b1;
          end
        end
        ST_WAIT: begin
          strobe.cntInc = 1'b1;
          if (pwmS) begin
            stateNext     = ST_DEAD;
            strobe.cntClr = 1'b1;
          end else if (status.seen && lowS) begin
            stateNext = ST_LS;
          end else if (!status.seen && status.fixedHit) begin
            stateNext = ST_LS;
          end else if (status.toutHit) begin
            stateNext = ST_LS;
          end
        end
        ST_LS: begin
          if (pwmS) begin
            stateNext     = ST_DEAD;
            strobe.cntClr = 1'b1;
          end
        end
        ST_DEAD: begin
          strobe.cntInc = 1'b1;
          if (!pwmS)               stateNext = ST_LS;
          else if (status.deadHit) stateNext = ST_HS;
        end
        default: stateNext = ST_OFF;
      endcase
    end
  end

  assign hsGate = (stateQ == ST_HS);
  assign lsGate = (stateQ == ST_LS);

  // checker counters
  logic [CNT_W-1:0] lowRun;
  logic [CNT_W-1:0] waitRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           lowRun <= '0;
    else if (lsGate)                     lowRun <= '0;
    else if (lowRun != CNT_W'(DEAD_LH))  lowRun <= lowRun + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   waitRun <= '0;
    else if (stateQ == ST_WAIT)  waitRun <= waitRun + 1'b1;
    else                         waitRun <= '0;
  end

  p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(hsGate && lsGate));

  p_disable_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    !enIn |=> (!hsGate && !lsGate));

  p_dead_gap_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsGate) |-> (lowRun >= CNT_W'(DEAD_LH)));

  p_timeout_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAIT) |-> (waitRun < CNT_W'(TIMEOUT_DLY)));

  p_fixed_path_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(lsGate) && ($past(stateQ) == ST_WAIT) && !$past(status.seen))
      |-> ($past(waitRun) == CNT_W'(FIXED_DLY - 1)));

  p_cancel_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAIT && pwmS && enIn) |=> !lsGate);

endmodule

// File: rtl/gate_deadtime_ctrl.sv
module gate_deadtime_ctrl
  import dtc_pkg::*;
#(
  parameter int FIXED_DLY   = 15,
  parameter int TIMEOUT_DLY = 19,
  parameter int DEAD_LH     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic enIn,
  input  logic pwmIn,
  input  logic nodeHighIn,
  input  logic nodeLowIn,
  output logic hsGateOut,
  output logic lsGateOut
);

  localparam int MAX_A   = (FIXED_DLY > TIMEOUT_DLY) ? FIXED_DLY : TIMEOUT_DLY;
  localparam int MAX_DLY = (MAX_A > DEAD_LH) ? MAX_A : DEAD_LH;
  localparam int CNT_W   = $clog2(MAX_DLY + 2);

  logic [2:0] syncBus;
  logic       pwmS, highS, lowS;
  dtcStrobe_t strobe;
  dtcStatus_t status;

  dtc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({pwmIn, nodeHighIn, nodeLowIn}),
    .syncOut (syncBus)
  );

  assign {pwmS, highS, lowS} = syncBus;

  dtc_datapath #(
    .CNT_W(CNT_W), .FIXED_DLY(FIXED_DLY),
    .TIMEOUT_DLY(TIMEOUT_DLY), .DEAD_LH(DEAD_LH)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .highS  (highS),
    .strobe (strobe),
    .status (status)
  );

  dtc_ctrl #(
    .CNT_W(CNT_W), .FIXED_DLY(FIXED_DLY),
    .TIMEOUT_DLY(TIMEOUT_DLY), .DEAD_LH(DEAD_LH)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .enIn   (enIn),
    .pwmS   (pwmS),
    .lowS   (lowS),
    .status (status),
    .strobe (strobe),
    .hsGate (hsGateOut),
    .lsGate (lsGateOut)
  );

endmodule

// File: tb/gate_deadtime_ctrl_tb.sv
module gate_deadtime_ctrl_tb;

  localparam int FIX = 15;
  localparam int TO  = 19;
  localparam int DL  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enIn = 1'b0, pwmIn = 1'b0, nodeHighIn = 1'b0, nodeLowIn = 1'b0;
  logic hs, ls;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  gate_deadtime_ctrl u_dut (
    .clk(clk), .rstN(rstN), .enIn(enIn), .pwmIn(pwmIn),
    .nodeHighIn(nodeHighIn), .nodeLowIn(nodeLowIn),
    .hsGateOut(hs), .lsGateOut(ls)
  );

  // reference model built from the requirements
  logic [2:0] q1, q2;
  int  mMode;   // 0 off, 1 high on, 2 waiting, 3 low on, 4 dead
  int  mCount;
  bit  mSeen;

  always @(posedge clk or negedge rstN) begin
    int nm; int nc; bit ns;
    if (!rstN) begin
      q1 <= '0; q2 <= '0; mMode <= 0; mCount <= 0; mSeen <= 0;
    end else begin
      nm = mMode; nc = mCount + 1; ns = mSeen | q2[1];
      if (!enIn) nm = 0;
      else begin
        case (mMode)
          0: if (q2[2]) begin nm = 4; nc = 0; end
             else begin nm = 2; nc = 0; ns = 0; end
          1: if (!q2[2]) begin nm = 2; nc = 0; ns = 0; end
          2: if (q2[2]) begin nm = 4; nc = 0; end
             else if (mSeen && q2[0]) nm = 3;
             else if (!mSeen && mCount == FIX - 1) nm = 3;
             else if (mCount == TO - 1) nm = 3;
          3: if (q2[2]) begin nm = 4; nc = 0; end
          default: if (!q2[2]) nm = 3; else if (mCount == DL - 1) nm = 1;
        endcase
      end
      q1 <= {pwmIn, nodeHighIn, nodeLowIn};
      q2 <= q1;
      mMode <= nm; mCount <= nc; mSeen <= ns;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!finished) begin
      chk("R3 overlap", int'(hs && ls), 0);
      chk("R1 model", int'({hs, ls}), int'({mMode == 1, mMode == 3}));
    end
  end

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic untilHsLow();
    for (int i = 0; i < 100 && hs; i++) @(negedge clk);
  endtask

  task automatic countUntilLs(output int n);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); n++;
      if (ls) break;
    end
  endtask

  task automatic countUntilHs(output int n);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); n++;
      if (hs) break;
    end
  endtask

  task automatic hsSteady();
    pwmIn = 1; nodeHighIn = 0; nodeLowIn = 0; cyc(12);
  endtask

  task automatic lsSteady();
    pwmIn = 0; nodeHighIn = 0; nodeLowIn = 0; cyc(30);
  endtask

  initial begin
    int n;
    bit lsEver;
    void'($urandom(32'h5eed1234));
    // R10 reset
    cyc(3);
    chk("R10 reset hs", int'(hs), 0);
    chk("R10 reset ls", int'(ls), 0);
    rstN = 1;
    pwmIn = 1;
    cyc(5);
    chk("R2 disabled hs", int'(hs), 0);
    chk("R2 disabled ls", int'(ls), 0);

    // R9 enable with pwm high
    enIn = 1;
    countUntilHs(n);
    chk("R9 first hs edges", n, DL + 1);

    // R1 steady and hs turn-off latency
    cyc(5);
    chk("R1 steady hs", int'(hs), 1);
    chk("R1 steady ls", int'(ls), 0);
    pwmIn = 0;
    n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); n++;
      if (!hs) break;
    end
    chk("R1 hs off latency", n, 3);

    // R5 fixed delay, node never high
    countUntilLs(n);
    chk("R5 fixed delay", n, FIX);
    cyc(5);
    chk("R1 steady ls", int'(ls), 1);

    // R7 dead time low to high
    pwmIn = 1;
    for (int i = 0; i < 20 && ls; i++) @(negedge clk);
    n = 0;
    while (!hs && n < 20) begin
      if (!ls) n++;
      @(negedge clk);
    end
    chk("R7 dead cycles", n, DL);

    // R4 adaptive path
    cyc(8);
    pwmIn = 0; nodeHighIn = 1;
    untilHsLow();
    cyc(4);
    nodeHighIn = 0; nodeLowIn = 1;
    countUntilLs(n);
    chk("R4 adaptive edges", n, 3);
    nodeLowIn = 0;

    // R6 timeout
    hsSteady();
    pwmIn = 0; nodeHighIn = 1;
    untilHsLow();
    countUntilLs(n);
    chk("R6 timeout", n, TO);
    nodeHighIn = 0;

    // R8 cancel pending low-side turn-on
    hsSteady();
    pwmIn = 0;
    untilHsLow();
    cyc(5);
    pwmIn = 1;
    lsEver = 0; n = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (ls) lsEver = 1;
      if (hs && n == 0) n = i + 1;
    end
    chk("R8 ls stayed low", int'(lsEver), 0);
    chk("R8 hs edges", n, 6);

    // R2 disable while high side on
    cyc(4);
    enIn = 0;
    @(negedge clk);
    chk("R2 drop hs", int'(hs), 0);
    chk("R2 drop ls", int'(ls), 0);
    lsEver = 0;
    for (int i = 0; i < 12; i++) begin
      pwmIn = i[1]; nodeHighIn = i[2];
      @(negedge clk);
      if (hs || ls) lsEver = 1;
    end
    chk("R2 held low", int'(lsEver), 0);

    // R9 enable with pwm low
    pwmIn = 0; nodeHighIn = 0;
    cyc(4);
    enIn = 1;
    countUntilLs(n);
    chk("R9 first ls edges", n, FIX + 1);

    // constrained random, checked by the model every cycle
    for (int it = 0; it < 150; it++) begin
      int hLen, lLen, mode, d1, d2;
      hLen = int'($urandom_range(6, 50));
      pwmIn = 1; nodeHighIn = 0; nodeLowIn = 0;
      cyc(hLen);
      mode = int'($urandom_range(0, 3));
      lLen = (it % 4 == 0) ? int'($urandom_range(3, 12)) : int'($urandom_range(10, 45));
      d1 = int'($urandom_range(1, 8));
      d2 = d1 + int'($urandom_range(1, 12));
      pwmIn = 0;
      for (int c = 0; c < lLen; c++) begin
        if ((mode == 1 || mode == 2) && c == d1) nodeHighIn = 1;
        if ((mode == 1 && c == d2) || (mode == 3 && c == d1)) begin
          nodeHighIn = 0; nodeLowIn = 1;
        end
        @(negedge clk);
      end
      if (it % 17 == 5) begin
        enIn = 0;
        cyc(int'($urandom_range(1, 6)));
        enIn = 1;
      end
    end
    lsSteady();
    report();
  end

endmodule